// File: doc/BRIEF.md
# Carry-Chained Arithmetic and Logic Unit

This block is the arithmetic stage of a small command-macro processor. Each cycle it takes an operation code and two operands and forms the result combinationally. It keeps a single carry flag between operations. The four arithmetic operations read this flag and rewrite it, so a wide sum or difference can be built as a chain of word-sized steps. The five bitwise operations leave the flag alone. The flag only changes on a clock edge when the commit enable is high, which lets the surrounding pipeline decide whether an operation really retires.

On subtraction the flag means "no borrow". A plain subtract sets it when the first operand is at least as large as the second. Subtract-with-borrow takes away one extra only when the flag is clear. Codes 4 to 7 and 13 to 31 are holes in the encoding. They produce a zero result, raise an illegal-operation output and never touch the flag.

Top module: `carry_alu`

## Requirements
- R1: Code 0 (add) gives the low WIDTH bits of a + b. When committed, it sets carry exactly when the unsigned sum exceeds 2^WIDTH - 1.
- R2: Code 1 (add with carry) gives a + b + carry. Its carry-out follows the same overflow rule as R1.
- R3: Code 2 (subtract) gives a - b modulo 2^WIDTH. When committed, it sets carry when a >= b, which means no borrow occurred.
- R4: Code 3 (subtract with borrow) gives a - b - 1 when carry is clear and a - b when carry is set. When committed, it sets carry when no borrow occurred, that is, when a >= b + (carry ? 0 : 1).
- R5: The bitwise codes give these results: 8 gives a ^ b, 9 gives a | b, 10 gives a & b, 11 gives a & ~b, and 12 gives ~(a & b).
- R6: A committed bitwise operation leaves the carry flag unchanged.
- R7: Codes 4 to 7 and 13 to 31 give a zero result and drive illegal high, and they leave carry unchanged. All legal codes drive illegal low.
- R8: The result follows the inputs without a clock. The carry flag changes only on a rising edge with en high.
- R9: A synchronous reset clears the carry flag. Reset takes priority over en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Commit enable for the carry update |
| op | input | 5 | Operation code |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| result | output | WIDTH | Combinational result |
| carry | output | 1 | Current carry flag |
| illegal | output | 1 | High when op is not a valid code |

## Verification
The bench builds the block with the default WIDTH of 32. This places the all-ones operand and the 2^32 wrap point within the directed stimulus. It can therefore check the carry out of an add that overflows, a subtract of equal operands, and a borrow chain that crosses zero against 64-bit arithmetic in the bench. Holding the width at the chip's word size also lets the bench check the exact code boundaries at 3/4, 7/8 and 12/13.

// File: rtl/carry_alu.sv
module carry_alu #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [4:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] result,
  output logic             carry,
  output logic             illegal
);
  localparam logic [4:0] OP_ADD  = 5'd0;
  localparam logic [4:0] OP_ADC  = 5'd1;
  localparam logic [4:0] OP_SUB  = 5'd2;
  localparam logic [4:0] OP_SBB  = 5'd3;
  localparam logic [4:0] OP_XOR  = 5'd8;
  localparam logic [4:0] OP_OR   = 5'd9;
  localparam logic [4:0] OP_AND  = 5'd10;
  localparam logic [4:0] OP_ANDN = 5'd11;
  localparam logic [4:0] OP_NAND = 5'd12;

  logic             carry_q;
  logic [WIDTH:0]   sum_w;
  logic [WIDTH:0]   diff_w;
  logic             add_cin;
  logic             sub_bin;
  logic             is_arith;
  logic             carry_nxt;

  assign is_arith = (op[4:2] == 3'b000);
  assign add_cin  = (op == OP_ADC) & carry_q;
  assign sub_bin  = (op == OP_SBB) & ~carry_q;
  assign sum_w    = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, add_cin};
  assign diff_w   = {1'b0, a} - {1'b0, b} - {{WIDTH{1'b0}}, sub_bin};
  assign carry_nxt = op[1] ? ~diff_w[WIDTH] : sum_w[WIDTH];

  always_comb begin
    result  = '0;
    illegal = 1'b0;
    case (op)
      OP_ADD, OP_ADC: result = sum_w[WIDTH-1:0];
      OP_SUB, OP_SBB: result = diff_w[WIDTH-1:0];
      OP_XOR:         result = a ^ b;
      OP_OR:          result = a | b;
      OP_AND:         result = a & b;
      OP_ANDN:        result = a & ~b;
      OP_NAND:        result = ~(a & b);
      default:        illegal = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                carry_q <= 1'b0;
    else if (en && is_arith) carry_q <= carry_nxt;
  end

  assign carry = carry_q;

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !carry); // R9
  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(carry)); // R8
  AST_BITWISE_KEEPS: assert property (@(posedge clk) disable iff (rst) (en && op[3] && !illegal) |=> $stable(carry)); // R6
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst) illegal |-> (result == '0)); // R7
  AST_ILLEGAL_KEEPS: assert property (@(posedge clk) disable iff (rst) illegal |=> $stable(carry)); // R7
  AST_SUB_EQUAL_NOBORROW: assert property (@(posedge clk) disable iff (rst) (en && op == OP_SUB && a == b) |=> carry); // R3
endmodule

// File: tb/test_carry_alu.sv
module test_carry_alu;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic [4:0]   op = 5'd0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [W-1:0] result;
  logic         carry;
  logic         illegal;

  int checks = 0;
  int errors = 0;
  logic model_c = 1'b0;
  bit done = 0;

  carry_alu #(.WIDTH(W)) i_carry_alu (
    .clk(clk), .rst(rst), .en(en), .op(op), .a(a), .b(b),
    .result(result), .carry(carry), .illegal(illegal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit legal(input logic [4:0] o);
    return (o <= 5'd3) || (o >= 5'd8 && o <= 5'd12);
  endfunction

  // Applies one operation, checks the combinational outputs, then the committed carry.
  task automatic step(input string req, input logic [4:0] o, input logic [W-1:0] x,
                      input logic [W-1:0] y, input logic e);
    logic [63:0] ex, ey, full;
    logic [W-1:0] exp_r;
    logic new_c;
    @(negedge clk);
    op = o; a = x; b = y; en = e;
    #1;
    ex = {32'd0, x}; ey = {32'd0, y};
    new_c = model_c;
    full = '0;
    case (o)
      5'd0: begin full = ex + ey; new_c = full > 64'hFFFF_FFFF; end
      5'd1: begin full = ex + ey + {63'd0, model_c}; new_c = full > 64'hFFFF_FFFF; end
      5'd2: begin full = ex - ey; new_c = ex >= ey; end
      5'd3: begin full = ex - ey - {63'd0, ~model_c}; new_c = ex >= ey + {63'd0, ~model_c}; end
      5'd8: full = ex ^ ey;
      5'd9: full = ex | ey;
      5'd10: full = ex & ey;
      5'd11: full = ex & ~ey;
      5'd12: full = ~(ex & ey);
      default: full = '0;
    endcase
    exp_r = full[W-1:0];
    chk({req, " result"}, {32'd0, result}, {32'd0, exp_r});
    chk({req, " illegal"}, {63'd0, illegal}, {63'd0, !legal(o)});
    chk({req, " carry before edge (R8)"}, {63'd0, carry}, {63'd0, model_c});
    @(posedge clk); #1;
    if (e) model_c = new_c;
    chk({req, " carry after edge"}, {63'd0, carry}, {63'd0, model_c});
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1'b1; en = 1'b1; op = 5'd0; a = '1; b = 32'd1;
    @(posedge clk); #1;
    model_c = 1'b0;
    chk("R9 reset clears carry", {63'd0, carry}, 64'd0);
    @(negedge clk); rst = 1'b0; en = 1'b0;
  endtask

  task automatic t_add;
    step("R1 add no overflow", 5'd0, 32'h1234_0000, 32'h0000_5678, 1'b1);
    step("R1 add overflow", 5'd0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1);
    step("R1 add max+max", 5'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
  endtask

  task automatic t_adc;
    step("R2 adc carry set", 5'd1, 32'h0000_0010, 32'h0000_0020, 1'b1);
    step("R2 adc carry clear", 5'd1, 32'h0000_0010, 32'h0000_0020, 1'b1);
    step("R1 setup carry", 5'd0, 32'h8000_0000, 32'h8000_0000, 1'b1);
    step("R2 adc ripple wrap", 5'd1, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1);
  endtask

  task automatic t_sub;
    step("R3 sub equal", 5'd2, 32'h0000_0055, 32'h0000_0055, 1'b1);
    step("R3 sub borrow", 5'd2, 32'h0000_0001, 32'h0000_0002, 1'b1);
    step("R4 sbb carry clear", 5'd3, 32'h0000_0010, 32'h0000_0010, 1'b1);
    step("R4 sbb carry clear again", 5'd3, 32'h0000_0011, 32'h0000_0010, 1'b1);
    step("R4 sbb carry set", 5'd3, 32'h0000_0011, 32'h0000_0010, 1'b1);
    step("R4 sbb zero minus zero", 5'd3, 32'h0, 32'h0, 1'b1);
  endtask

  task automatic t_bitwise;
    step("R1 setup carry", 5'd0, 32'hFFFF_FFFF, 32'h1, 1'b1);
    step("R5 R6 xor", 5'd8, 32'hF0F0_1234, 32'h0FF0_FFFF, 1'b1);
    step("R5 R6 or", 5'd9, 32'hF000_0001, 32'h000F_0010, 1'b1);
    step("R5 R6 and", 5'd10, 32'hFF00_FF00, 32'h0FF0_0FF0, 1'b1);
    step("R5 R6 andnot", 5'd11, 32'hFFFF_0000, 32'hF0F0_F0F0, 1'b1);
    step("R5 R6 nand", 5'd12, 32'hFFFF_0000, 32'hF0F0_F0F0, 1'b1);
    chk("R6 carry still set", {63'd0, carry}, 64'd1);
  endtask

  task automatic t_illegal;
    step("R7 code 4", 5'd4, 32'hFFFF_FFFF, 32'h1, 1'b1);
    step("R7 code 7", 5'd7, 32'hFFFF_FFFF, 32'h1, 1'b1);
    step("R7 code 13", 5'd13, 32'h1234_5678, 32'h1, 1'b1);
    step("R7 code 31", 5'd31, 32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
    step("R2 after illegal", 5'd1, 32'h0, 32'h0, 1'b1);
  endtask

  task automatic t_enable;
    step("R8 add no commit", 5'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    step("R8 sub no commit", 5'd2, 32'h5, 32'h1, 1'b0);
    step("R8 sub commit", 5'd2, 32'h5, 32'h1, 1'b1);
    step("R8 sub borrow no commit", 5'd2, 32'h1, 32'h5, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_add();
    t_adc();
    t_sub();
    t_bitwise();
    t_illegal();
    t_enable();
    step("R1 setup carry", 5'd0, 32'hFFFF_FFFF, 32'h1, 1'b1);
    t_reset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule